// File: doc/BRIEF.md
# Static Memory Read Cycle Sequencer

This block runs read cycles on an asynchronous static memory bus. A host raises a request with a word address and the block acknowledges it in the same cycle. The block then latches the address, the timing settings and the sampling mode. It drives an active-low chip select, an active-low read strobe, active-low byte selects and the address. At the end of the cycle it returns the captured word with a one-cycle done pulse.

The chip select and the read strobe each have their own setup, pulse and total-cycle counts, measured in controller clock cycles. Hold time is whatever is left of the total after setup and pulse, so the two strobes can fall and rise in different cycles. A mode input chooses which strobe's rising edge samples the memory data. The bus cycle lasts as long as the longer of the two effective totals. No new request is accepted until that cycle has finished.

Top module: `sram_rd_seq`

## Requirements
- R1: While reset is held and right after it is released, mem_cs_no and mem_rd_no are 1, mem_be_no is all ones, done_o is 0 and ack_o follows req_i.
- R2: ack_o is high exactly when req_i is high and no cycle is in flight. The acceptance edge is the clock edge at which ack_o is high. At that edge, addr_i, the six timing inputs and sample_rd_i are captured. mem_addr_o then holds the captured address until the next acceptance, and later changes to any of those inputs have no effect on the running cycle.
- R3: Cycle k is the k-th cycle after the acceptance edge, starting at k = 0. mem_cs_no is 0 exactly in cycles k where cs_setup <= k < cs_setup + cs_pulse.
- R4: mem_rd_no is 0 exactly in cycles k where rd_setup <= k < rd_setup + rd_pulse.
- R5: A pulse setting of 0 behaves as a pulse of 1 for either strobe.
- R6: The effective total of each strobe is max(total, setup + effective pulse), so hold = total - setup - pulse is never negative. The cycle spans T = the larger of the two effective totals. done_o is high only in cycle k = T.
- R7: With sample_rd_i = 1, data_o in the done cycle equals the value of mem_data_i at the clock edge where mem_rd_no rises.
- R8: With sample_rd_i = 0, data_o in the done cycle equals the value of mem_data_i at the clock edge where mem_cs_no rises.
- R9: mem_be_no is all zeros in cycles 0 to T-1 and all ones in every other cycle.
- R10: While a cycle is in flight (cycles 0 to T-1), ack_o stays low even if req_i is high.
- R11: Outside cycles 0 to T-1, both mem_cs_no and mem_rd_no are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host read request |
| addr_i | input | ADDR_W | Host word address |
| cs_setup_i | input | CNT_W | Chip select setup count |
| cs_pulse_i | input | CNT_W | Chip select pulse count |
| cs_total_i | input | CNT_W | Chip select total-cycle count |
| rd_setup_i | input | CNT_W | Read strobe setup count |
| rd_pulse_i | input | CNT_W | Read strobe pulse count |
| rd_total_i | input | CNT_W | Read strobe total-cycle count |
| sample_rd_i | input | 1 | 1: sample on read strobe rise, 0: sample on chip select rise |
| ack_o | output | 1 | Request accepted this cycle |
| done_o | output | 1 | One-cycle pulse, data_o valid |
| data_o | output | DATA_W | Captured read word |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_be_no | output | DATA_W/8 | Byte selects, active low |
| mem_cs_no | output | 1 | Chip select, active low |
| mem_rd_no | output | 1 | Read strobe, active low |
| mem_data_i | input | DATA_W | Memory read data |

## Verification
A wrong cycle counter or a badly latched setting shows at once as a strobe edge one or more cycles away from its programmed position, because every strobe output changes on the edge that follows the count. A clamping fault shows as done_o arriving in the wrong cycle, or as a strobe that stays low past the end of the cycle. A wrong sampling edge or mode shows only in the done cycle, as a data_o value that belongs to the neighbouring cycle. The bench places a different word on mem_data_i in every cycle, so a capture that is off by one edge produces a wrong value.

// File: rtl/srd_pkg.sv
package srd_pkg;
  localparam int unsigned CNT_W = 4;

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [CNT_W:0]   span_t;

  typedef struct packed {
    cnt_t setup;
    cnt_t pulse;
    cnt_t total;
  } tmg_raw_t;

  typedef struct packed {
    span_t setup;
    span_t pulse;
    span_t total;
  } tmg_t;

  typedef enum logic {
    SAMPLE_CS = 1'b0,
    SAMPLE_RD = 1'b1
  } sample_e;

  localparam int unsigned N_STROBE = 2;
  localparam int unsigned IDX_CS   = 0;
  localparam int unsigned IDX_RD   = 1;
endpackage

// File: rtl/srd_cfg_clamp.sv
module srd_cfg_clamp
  import srd_pkg::*;
(
  input  tmg_raw_t raw_i,
  output tmg_t     eff_o
);
  span_t pulse_eff;
  span_t active_end;
  span_t total_raw;

  always_comb begin
    pulse_eff  = (raw_i.pulse == '0) ? span_t'(1) : {1'b0, raw_i.pulse};
    active_end = {1'b0, raw_i.setup} + pulse_eff;
    total_raw  = {1'b0, raw_i.total};
    eff_o.setup = {1'b0, raw_i.setup};
    eff_o.pulse = pulse_eff;
    // hold may never go negative: stretch total to cover setup + pulse
    eff_o.total = (total_raw < active_end) ? active_end : total_raw;
  end
endmodule

// File: rtl/srd_strobe.sv
module srd_strobe
  import srd_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  load_i,
  input  tmg_t  cfg_i,
  input  logic  run_nxt_i,
  input  span_t cnt_nxt_i,
  input  logic  busy_i,
  input  span_t cnt_i,
  output logic  strobe_no,
  output logic  rise_o,
  output span_t total_o
);
  tmg_t  cfg_q;
  tmg_t  cfg_use;
  span_t win_end_nxt;
  span_t win_end_q;
  logic  strobe_d;

  always_comb begin
    cfg_use     = load_i ? cfg_i : cfg_q;
    win_end_nxt = cfg_use.setup + cfg_use.pulse;
    win_end_q   = cfg_q.setup + cfg_q.pulse;
    strobe_d    = !(run_nxt_i && (cnt_nxt_i >= cfg_use.setup) && (cnt_nxt_i < win_end_nxt));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      strobe_no <= 1'b1;
    end else begin
      if (load_i) cfg_q <= cfg_i;
      strobe_no <= strobe_d;
    end
  end

  // last active cycle: the coming edge releases the strobe
  assign rise_o  = busy_i && !strobe_no && (cnt_i == win_end_q - span_t'(1));
  assign total_o = cfg_q.total;
endmodule

// File: rtl/sram_rd_seq.sv
module sram_rd_seq
  import srd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CNT_W-1:0]      cs_setup_i,
  input  logic [CNT_W-1:0]      cs_pulse_i,
  input  logic [CNT_W-1:0]      cs_total_i,
  input  logic [CNT_W-1:0]      rd_setup_i,
  input  logic [CNT_W-1:0]      rd_pulse_i,
  input  logic [CNT_W-1:0]      rd_total_i,
  input  logic                  sample_rd_i,
  output logic                  ack_o,
  output logic                  done_o,
  output logic [DATA_W-1:0]     data_o,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic [DATA_W/8-1:0]   mem_be_no,
  output logic                  mem_cs_no,
  output logic                  mem_rd_no,
  input  logic [DATA_W-1:0]     mem_data_i
);
  localparam int unsigned BE_W = DATA_W / 8;

  tmg_raw_t raw   [N_STROBE];
  tmg_t     eff   [N_STROBE];
  logic     strb_n[N_STROBE];
  logic     rise  [N_STROBE];
  span_t    tot   [N_STROBE];

  logic              busy_q;
  span_t             cnt_q;
  span_t             cnt_nxt;
  span_t             span;
  logic              last;
  logic              accept;
  logic              run_nxt;
  sample_e           mode_q;
  logic              sel_rise;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [BE_W-1:0]   be_n_q;
  logic              done_q;

  always_comb begin
    raw[IDX_CS] = '{setup: cs_setup_i, pulse: cs_pulse_i, total: cs_total_i};
    raw[IDX_RD] = '{setup: rd_setup_i, pulse: rd_pulse_i, total: rd_total_i};
  end

  for (genvar g = 0; g < N_STROBE; g++) begin : g_strobe
    srd_cfg_clamp u_clamp (
      .raw_i (raw[g]),
      .eff_o (eff[g])
    );
    srd_strobe u_strobe (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .load_i    (accept),
      .cfg_i     (eff[g]),
      .run_nxt_i (run_nxt),
      .cnt_nxt_i (cnt_nxt),
      .busy_i    (busy_q),
      .cnt_i     (cnt_q),
      .strobe_no (strb_n[g]),
      .rise_o    (rise[g]),
      .total_o   (tot[g])
    );
  end

  always_comb begin
    span    = (tot[IDX_CS] > tot[IDX_RD]) ? tot[IDX_CS] : tot[IDX_RD];
    last    = busy_q && (cnt_q == span - span_t'(1));
    accept  = req_i && !busy_q;
    run_nxt = accept || (busy_q && !last);
    if (accept)                cnt_nxt = '0;
    else if (busy_q && !last)  cnt_nxt = cnt_q + span_t'(1);
    else                       cnt_nxt = cnt_q;
    sel_rise = (mode_q == SAMPLE_RD) ? rise[IDX_RD] : rise[IDX_CS];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= SAMPLE_CS;
      addr_q <= '0;
      data_q <= '0;
      be_n_q <= '1;
      done_q <= 1'b0;
    end else begin
      busy_q <= run_nxt;
      cnt_q  <= cnt_nxt;
      be_n_q <= run_nxt ? '0 : '1;
      done_q <= last;
      if (accept) begin
        addr_q <= addr_i;
        mode_q <= sample_e'(sample_rd_i);
      end
      if (sel_rise) data_q <= mem_data_i;
    end
  end

  assign ack_o      = accept;
  assign done_o     = done_q;
  assign data_o     = data_q;
  assign mem_addr_o = addr_q;
  assign mem_be_no  = be_n_q;
  assign mem_cs_no  = strb_n[IDX_CS];
  assign mem_rd_no  = strb_n[IDX_RD];
endmodule

// File: rtl/sram_rd_seq_chk.sv
module sram_rd_seq_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned BE_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ack_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [BE_W-1:0]   mem_be_no,
  input logic              mem_cs_no,
  input logic              mem_rd_no
);
  a_r2_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |=> $stable(mem_addr_o));

  a_r10_no_ack_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (&mem_be_no));

  a_r11_idle_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mem_be_no) |-> (mem_cs_no && mem_rd_no));

  a_r9_be_uniform: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_be_no == '0) || (&mem_be_no));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_after_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(mem_be_no == '0));
endmodule

bind sram_rd_seq sram_rd_seq_chk #(.ADDR_W(ADDR_W), .BE_W(DATA_W/8)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ack_o      (ack_o),
  .done_o     (done_o),
  .mem_addr_o (mem_addr_o),
  .mem_be_no  (mem_be_no),
  .mem_cs_no  (mem_cs_no),
  .mem_rd_no  (mem_rd_no)
);

// File: tb/sram_rd_seq_test.sv
`timescale 1ns/1ps
module sram_rd_seq_test;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int CW     = srd_pkg::CNT_W;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [CW-1:0]     cs_setup_i = '0, cs_pulse_i = '0, cs_total_i = '0;
  logic [CW-1:0]     rd_setup_i = '0, rd_pulse_i = '0, rd_total_i = '0;
  logic              sample_rd_i = 1'b0;
  logic              ack_o, done_o, mem_cs_no, mem_rd_no;
  logic [DATA_W-1:0] data_o, mem_data_i = '0;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [DATA_W/8-1:0] mem_be_no;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk_i = ~clk_i;

  sram_rd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mdat(input int addr, input int k);
    return DATA_W'(addr * 40503) ^ DATA_W'(k * 257) ^ 16'h5a3c;
  endfunction

  function automatic int eff_pulse(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  function automatic int eff_total(input int s, input int p, input int t);
    return (t < s + eff_pulse(p)) ? s + eff_pulse(p) : t;
  endfunction

  task automatic do_read(input int cs_s, input int cs_p, input int cs_t,
                         input int rd_s, input int rd_p, input int rd_t,
                         input bit mode, input int addr, input bit press, input string xtag);
    int ecp, erp, tt, ks;
    logic [63:0] cs_act, cs_exp, rd_act, rd_exp, be_act, be_exp, dn_act, dn_exp;
    bit ack_ok, addr_ok;
    ecp = eff_pulse(cs_p);
    erp = eff_pulse(rd_p);
    tt  = eff_total(cs_s, cs_p, cs_t);
    if (eff_total(rd_s, rd_p, rd_t) > tt) tt = eff_total(rd_s, rd_p, rd_t);
    ks  = mode ? rd_s + erp - 1 : cs_s + ecp - 1;
    cs_act = '0; cs_exp = '0; rd_act = '0; rd_exp = '0;
    be_act = '0; be_exp = '0; dn_act = '0; dn_exp = '0;
    ack_ok = 1'b1; addr_ok = 1'b1;

    @(negedge clk_i);
    cs_setup_i = CW'(cs_s); cs_pulse_i = CW'(cs_p); cs_total_i = CW'(cs_t);
    rd_setup_i = CW'(rd_s); rd_pulse_i = CW'(rd_p); rd_total_i = CW'(rd_t);
    sample_rd_i = mode;
    addr_i = ADDR_W'(addr);
    req_i = 1'b1;
    #1;
    chk(ack_o === 1'b1, "R2 ack on idle request", 64'(ack_o), 64'd1);
    @(posedge clk_i);
    @(negedge clk_i);
    for (int k = 0; k <= tt; k++) begin
      req_i = press && (k < tt - 1);
      addr_i = ADDR_W'($urandom);
      cs_setup_i = CW'($urandom); cs_pulse_i = CW'($urandom); cs_total_i = CW'($urandom);
      rd_setup_i = CW'($urandom); rd_pulse_i = CW'($urandom); rd_total_i = CW'($urandom);
      sample_rd_i = 1'($urandom);
      mem_data_i = mdat(addr, k);
      #1;
      cs_act[k] = mem_cs_no;
      rd_act[k] = mem_rd_no;
      be_act[k] = (mem_be_no == '0);
      dn_act[k] = done_o;
      cs_exp[k] = !(k >= cs_s && k < cs_s + ecp);
      rd_exp[k] = !(k >= rd_s && k < rd_s + erp);
      be_exp[k] = (k < tt);
      dn_exp[k] = (k == tt);
      if (k < tt && ack_o !== 1'b0) ack_ok = 1'b0;
      if (mem_addr_o !== ADDR_W'(addr)) addr_ok = 1'b0;
      if (k == tt)
        chk(data_o === mdat(addr, ks), mode ? "R7 data on read strobe rise" : "R8 data on chip select rise",
            64'(data_o), 64'(mdat(addr, ks)));
      if (k < tt) @(negedge clk_i);
    end
    req_i = 1'b0;
    chk(cs_act === cs_exp, {"R3 R11 chip select pattern ", xtag}, cs_act, cs_exp);
    chk(rd_act === rd_exp, {"R4 R11 read strobe pattern ", xtag}, rd_act, rd_exp);
    chk(be_act === be_exp, "R9 byte select window", be_act, be_exp);
    chk(dn_act === dn_exp, {"R6 done position ", xtag}, dn_act, dn_exp);
    chk(addr_ok, "R2 address held", 64'(mem_addr_o), 64'(addr));
    chk(ack_ok, "R10 no accept while busy", 64'(ack_ok), 64'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd7570;
    void'($urandom(seed));
    repeat (3) @(negedge clk_i);
    chk(mem_cs_no === 1'b1 && mem_rd_no === 1'b1, "R1 strobes idle in reset", {mem_cs_no, mem_rd_no}, 2'b11);
    chk(&mem_be_no === 1'b1 && done_o === 1'b0, "R1 byte selects and done in reset", {mem_be_no, done_o}, {2'b11, 1'b0});
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mem_cs_no === 1'b1 && mem_rd_no === 1'b1 && done_o === 1'b0, "R1 idle after reset",
        {mem_cs_no, mem_rd_no, done_o}, 3'b110);

    do_read(2, 3, 8, 3, 2, 7, 1'b1, 20'h12345, 1'b1, "basic");
    do_read(2, 3, 8, 3, 2, 7, 1'b0, 20'h0abcd, 1'b0, "basic");
    do_read(0, 1, 1, 0, 1, 1, 1'b1, 20'h00001, 1'b1, "minimum");
    do_read(1, 0, 0, 0, 0, 3, 1'b0, 20'h00077, 1'b1, "R5 zero pulse");
    do_read(3, 0, 2, 2, 0, 0, 1'b1, 20'h0f00f, 1'b0, "R5 zero pulse");
    do_read(5, 6, 4, 1, 2, 3, 1'b0, 20'h33333, 1'b1, "R6 total clamp");
    do_read(15, 15, 15, 0, 15, 15, 1'b1, 20'hfffff, 1'b1, "R6 total clamp");
    do_read(0, 4, 4, 4, 4, 15, 1'b0, 20'h55555, 1'b0, "late read strobe");
    do_read(4, 4, 15, 0, 4, 4, 1'b1, 20'haaaaa, 1'b1, "late chip select");

    for (int i = 0; i < 40; i++)
      do_read(int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
              int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
              1'($urandom), int'($urandom_range(0, (1 << ADDR_W) - 1)), 1'($urandom), "random");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule